// File: doc/BRIEF.md
# Vertical Sync Timing Generator

This block produces the vertical timing of a display controller by counting raster lines. A strobe from the horizontal timing logic marks each new line. A 10-bit line counter advances on every strobe. An active-low vertical sync output is driven low for three lines, starting at a programmable line. Horizontal timing and pixel generation are handled elsewhere.

The block has two modes. In free-running mode the scan-cycle value sets the frame length in lines. In TV-sync mode an external vertical sync input controls the frame. That input passes through a two-flop synchronizer. Each rising edge restarts the line counter. The scan-cycle value then becomes a watchdog limit: if it runs out before an edge arrives, a sticky timeout flag is set. In TV-sync mode, software should program the sync start line at or after the line on which the external sync input falls.

Three registers are reached through a simple write port with a combinational read:
- The start-line register.
- The scan-cycle register.
- A status word carrying the timeout flag.

Both timing values survive a reset. The sync shaping is done by a two-state machine:
- `ST_HIGH` is the sync-inactive state. Transition `HIGH->LOW` is taken when the counter moves onto the start line.
- `ST_LOW` is the sync-active state. Transition `LOW->HIGH` is taken on the third line strobe after entry.

Top module: `vsync_timing_gen`

## Requirements
- R1: After reset, `vsync_n` is 1, `line_cnt` is 0 and `tmo_flag` is 0.
- R2: Register map, selected by `reg_addr`:
  - Address 0 is the start line, held in data bits 9..0.
  - Address 1 is the scan cycle, held in data bits 9..0.
  - Address 2 is status, with the timeout flag in bit 0.
  - Read bits 15..10 always return zero, and address 3 reads as zero.
- R3: The start-line and scan-cycle values keep their contents across a reset.
- R4: In free-running mode (`mode_sel` not equal to 2'b10), each `line_stb` pulse advances `line_cnt` by one. When `line_cnt` is already at or above scan-cycle minus 1, the pulse wraps it to 0 instead.
- R5: `vsync_n` goes low in the same cycle that `line_cnt` takes the start-line value. It stays low through two further strobes and returns high on the third strobe after entry, giving three lines low.
- R6: In TV-sync mode (`mode_sel` = 2'b10), a rising edge on `ext_vsync` restarts `line_cnt` at 0. The restart is visible three clock edges after the input changes. In free-running mode the input has no effect.
- R7: In TV-sync mode, a strobe with `line_cnt` at or above scan-cycle minus 1, and no edge in the same cycle, does two things: it sets `tmo_flag` and it wraps `line_cnt` to 0.
- R8: `tmo_flag` is sticky. Only a write to address 2 with data bit 0 set clears it. A write with bit 0 clear leaves it unchanged. A new timeout in the same cycle as a clear wins over the clear.
- R9: `tmo_flag` is never set in free-running mode.
- R10: Without a strobe and without a TV-mode edge, `line_cnt` and `vsync_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per raster line |
| ext_vsync | input | 1 | External vertical sync input, asynchronous |
| mode_sel | input | 2 | 2'b10 selects TV-sync mode, any other value selects free-running mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| vsync_n | output | 1 | Vertical sync, active low |
| line_cnt | output | 10 | Current raster line |
| tmo_flag | output | 1 | Sticky external-sync timeout flag |

## Verification
Each fault shows up at the ports, and within a bounded time:
- A wrong counter value shows on `line_cnt` one cycle after the strobe that produced it.
- A wrong machine state moves the `vsync_n` fall or rise by at least one line, and this is seen at the first strobe after the error.
- A missed or spurious external edge appears as a counter that fails to restart three clocks after the input changes.
- A wrong watchdog comparison sets `tmo_flag` early, late or not at all. This is visible at the strobe that ends the window.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    typedef enum logic [0:0] {
        ST_HIGH = 1'b0,
        ST_LOW  = 1'b1
    } vs_state_t;

    typedef logic [1:0] reg_addr_t;

    localparam logic [1:0] MODE_TV   = 2'b10;
    localparam reg_addr_t  A_START   = 2'd0;
    localparam reg_addr_t  A_SCAN    = 2'd1;
    localparam reg_addr_t  A_STATUS  = 2'd2;
endpackage

// File: rtl/vsg_sync_edge.sv
module vsg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], din};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/vsg_regs.sv
module vsg_regs
    import vsg_pkg::*;
#(
    parameter int LW = 10,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  reg_addr_t     addr,
    input  logic [RW-1:0] wdata,
    input  logic          tmo_set,
    output logic [LW-1:0] start_q,
    output logic [LW-1:0] scan_q,
    output logic          flag_q,
    output logic [RW-1:0] rdata
);
    logic clr_req;
    logic unused_hi;

    assign unused_hi = ^wdata[RW-1:LW];
    assign clr_req   = wr && (addr == A_STATUS) && wdata[0];

    // timing values deliberately have no reset
    always_ff @(posedge clk) begin
        if (wr && addr == A_START) begin
            start_q <= wdata[LW-1:0];
        end
        if (wr && addr == A_SCAN) begin
            scan_q <= wdata[LW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (tmo_set) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_START:  rdata[LW-1:0] = start_q;
            A_SCAN:   rdata[LW-1:0] = scan_q;
            A_STATUS: rdata[0]      = flag_q;
            default:  rdata         = '0;
        endcase
    end
endmodule

// File: rtl/vsg_line_ctr.sv
module vsg_line_ctr #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_stb,
    input  logic          tv_mode,
    input  logic          ext_rise,
    input  logic [LW-1:0] scan_q,
    output logic [LW-1:0] lc_q,
    output logic [LW-1:0] lc_next,
    output logic          adv,
    output logic          tmo_set
);
    logic [LW-1:0] scan_m1;

    assign scan_m1 = scan_q - LW'(1);

    always_comb begin
        lc_next = lc_q;
        adv     = 1'b0;
        tmo_set = 1'b0;
        if (tv_mode && ext_rise) begin
            lc_next = '0;
            adv     = 1'b1;
        end else if (line_stb) begin
            adv = 1'b1;
            if (lc_q >= scan_m1) begin
                lc_next = '0;
                tmo_set = tv_mode;
            end else begin
                lc_next = lc_q + LW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_q <= '0;
        end else begin
            lc_q <= lc_next;
        end
    end
endmodule

// File: rtl/vsg_fsm.sv
module vsg_fsm
    import vsg_pkg::*;
#(
    parameter int LW  = 10,
    parameter int PW  = 3,
    localparam int WCW = (PW > 2) ? $clog2(PW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          line_stb,
    input  logic [LW-1:0] lc_next,
    input  logic [LW-1:0] start_q,
    output logic          vsync_n
);
    vs_state_t      state_q, state_n;
    logic [WCW-1:0] wcnt_q, wcnt_n;

    always_comb begin
        state_n = state_q;
        wcnt_n  = wcnt_q;
        unique case (state_q)
            ST_HIGH: begin
                if (adv && lc_next == start_q) begin
                    state_n = ST_LOW;
                    wcnt_n  = '0;
                end
            end
            ST_LOW: begin
                if (line_stb) begin
                    if (wcnt_q == WCW'(PW - 1)) begin
                        state_n = ST_HIGH;
                        wcnt_n  = '0;
                    end else begin
                        wcnt_n = wcnt_q + WCW'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HIGH;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            wcnt_q  <= wcnt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_n <= 1'b1;
        end else begin
            vsync_n <= (state_n != ST_LOW);
        end
    end
endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
    import vsg_pkg::*;
#(
    parameter int LW     = 10,
    parameter int RW     = 16,
    parameter int PW     = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_stb,
    input  logic          ext_vsync,
    input  logic [1:0]    mode_sel,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          vsync_n,
    output logic [LW-1:0] line_cnt,
    output logic          tmo_flag
);
    logic          tv_mode;
    logic          ext_rise;
    logic [LW-1:0] start_q;
    logic [LW-1:0] scan_q;
    logic [LW-1:0] lc_next;
    logic          adv;
    logic          tmo_set;

    assign tv_mode = (mode_sel == MODE_TV);

    vsg_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_vsync),
        .rise (ext_rise)
    );

    vsg_regs #(.LW(LW), .RW(RW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .tmo_set(tmo_set),
        .start_q(start_q),
        .scan_q (scan_q),
        .flag_q (tmo_flag),
        .rdata  (reg_rdata)
    );

    vsg_line_ctr #(.LW(LW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_stb(line_stb),
        .tv_mode (tv_mode),
        .ext_rise(ext_rise),
        .scan_q  (scan_q),
        .lc_q    (line_cnt),
        .lc_next (lc_next),
        .adv     (adv),
        .tmo_set (tmo_set)
    );

    vsg_fsm #(.LW(LW), .PW(PW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .line_stb(line_stb),
        .lc_next (lc_next),
        .start_q (start_q),
        .vsync_n (vsync_n)
    );
endmodule

// File: rtl/vsg_chk.sv
module vsg_chk #(
    parameter int LW = 10,
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_stb,
    input logic [1:0]    mode_sel,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [RW-1:0] reg_wdata,
    input logic [RW-1:0] reg_rdata,
    input logic          vsync_n,
    input logic [LW-1:0] line_cnt,
    input logic          tmo_flag,
    input logic [LW-1:0] start_q,
    input logic [LW-1:0] scan_q
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RW-1:LW] == '0); // R2

    AST_LC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && mode_sel != 2'b10 && line_cnt < scan_q - LW'(1))
        |=> line_cnt == $past(line_cnt) + LW'(1)); // R4

    AST_FALL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n) && $stable(start_q)) |-> line_cnt == start_q); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0])) |=> tmo_flag); // R8

    AST_FLAG_TV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(mode_sel) == 2'b10); // R9

    AST_LC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_stb && mode_sel != 2'b10) |=> ($stable(line_cnt) && $stable(vsync_n))); // R10
endmodule

bind vsync_timing_gen vsg_chk #(.LW(LW), .RW(RW)) u_vsg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .mode_sel (mode_sel),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .vsync_n  (vsync_n),
    .line_cnt (line_cnt),
    .tmo_flag (tmo_flag),
    .start_q  (start_q),
    .scan_q   (scan_q)
);

// File: tb/vsync_timing_gen_tb_top.sv
module vsync_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_stb = 1'b0;
    logic        ext_vsync = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        vsync_n;
    logic [9:0]  line_cnt;
    logic        tmo_flag;

    int total = 0;
    int bad = 0;

    typedef struct packed {
        logic       vs;
        logic [9:0] lc;
        logic       fl;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  mon_ev;

    // reference model state
    int m_lc = 0, m_w = 0, m_scan = 0, m_start = 0;
    bit m_low = 0, m_flag = 0, m_tv = 0;

    always #5 clk = ~clk;

    vsync_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .ext_vsync(ext_vsync),
        .mode_sel(mode_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vsync_n(vsync_n),
        .line_cnt(line_cnt), .tmo_flag(tmo_flag)
    );

    task automatic push(input string tag);
        exp_t e;
        e.vs = ~m_low;
        e.lc = 10'(m_lc);
        e.fl = m_flag;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> mon_ev;
        #1;
    endtask

    task automatic model_adv(input bit stb, input bit edg);
        int  nlc;
        bit  adv;
        nlc = m_lc;
        adv = 0;
        if (m_tv && edg) begin
            nlc = 0;
            adv = 1;
        end else if (stb) begin
            adv = 1;
            if (m_lc >= ((m_scan - 1) & 1023)) begin
                nlc = 0;
                if (m_tv) m_flag = 1;
            end else begin
                nlc = m_lc + 1;
            end
        end
        if (!m_low) begin
            if (adv && nlc == m_start) begin
                m_low = 1;
                m_w = 0;
            end
        end else if (stb) begin
            if (m_w == 2) m_low = 0;
            else m_w++;
        end
        m_lc = nlc;
    endtask

    task automatic line_step(input string tag);
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
        model_adv(1, 0);
        push(tag);
    endtask

    task automatic ext_edge(input string tag);
        @(negedge clk) ext_vsync = 1'b1;
        repeat (3) @(negedge clk);
        model_adv(0, 1);
        push(tag);
        @(negedge clk) ext_vsync = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) m_start = d[9:0];
        if (a == 2'd1) m_scan = d[9:0];
        if (a == 2'd2 && d[0]) m_flag = 0;
    endtask

    task automatic reg_check(input logic [1:0] a, input logic [15:0] expv, input string tag);
        @(negedge clk) reg_addr = a;
        #1;
        total++;
        if (reg_rdata !== expv) begin
            bad++;
            $display("FAIL %s: read addr %0d got %h expected %h", tag, a, reg_rdata, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lc = 0; m_w = 0; m_low = 0; m_flag = 0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : monitor
        exp_t  e;
        string t;
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (vsync_n !== e.vs || line_cnt !== e.lc || tmo_flag !== e.fl) begin
                    bad++;
                    $display("FAIL %s: got vs=%0b lc=%0d fl=%0b expected vs=%0b lc=%0d fl=%0b",
                             t, vsync_n, line_cnt, tmo_flag, e.vs, e.lc, e.fl);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hung run expected completion");
        summary();
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 reset state");
        reg_check(2'd2, 16'h0000, "R1 status after reset");

        // R2: register map, reserved bits read zero
        reg_write(2'd0, 16'hFC05);
        reg_write(2'd1, 16'h000A);
        reg_check(2'd0, 16'h0005, "R2 start readback");
        reg_check(2'd1, 16'h000A, "R2 scan readback");
        reg_check(2'd3, 16'h0000, "R2 unmapped address");

        // R4 / R5: free-running frames
        m_tv = 0;
        for (int i = 0; i < 25; i++) line_step("R4 R5 free run");

        // R10: idle cycles hold
        repeat (6) @(negedge clk);
        push("R10 hold without strobe");

        // R6: external edge ignored in free-running mode
        ext_edge("R6 edge ignored in free mode");

        // R3: values survive reset
        line_step("R4 before reset");
        do_reset();
        push("R1 R3 after second reset");
        reg_check(2'd0, 16'h0005, "R3 start retained");
        reg_check(2'd1, 16'h000A, "R3 scan retained");

        // R9: other non-TV encoding never times out
        mode_sel = 2'b01;
        for (int i = 0; i < 15; i++) line_step("R9 no flag outside TV mode");

        // TV-sync mode
        mode_sel = 2'b10;
        m_tv = 1;
        reg_write(2'd1, 16'h0008);
        reg_write(2'd0, 16'h0002);
        for (int i = 0; i < 3; i++) line_step("R7 TV counting");
        ext_edge("R6 edge restarts counter");
        for (int i = 0; i < 4; i++) line_step("R5 R6 TV lines");
        ext_edge("R6 second edge");
        for (int i = 0; i < 10; i++) line_step("R7 watchdog window");
        for (int i = 0; i < 3; i++) line_step("R8 flag sticky");
        reg_write(2'd2, 16'h0000);
        push("R8 write zero keeps flag");
        reg_check(2'd2, 16'h0001, "R8 status reads set");
        reg_write(2'd2, 16'h0001);
        push("R8 write one clears flag");
        ext_edge("R6 edge after clear");
        line_step("R8 flag stays clear");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule